// File: doc/BRIEF.md
# Graphics Coprocessor Host Register Window

This block is the register interface that a host processor sees when it talks to a graphics coprocessor. It decodes a byte-addressed window of 0x300 bytes. The window holds sixteen 16-bit general registers, a status word, a set of 8-bit control registers, a 16-bit cache base register and a byte-wide cache RAM. The host uses a synchronous byte bus. A write or read is issued in one cycle, and read data appears on the cycle after the request.

Some register accesses have side effects that make up the run/stop handshake with the execution core. Writing the upper byte of the program counter (R15) sets the running flag and sends a one-cycle start pulse to the core. When the core reports a stop, the running flag drops. If interrupts are not masked, a stop or an interrupt request from the core latches the status interrupt bit and drives an interrupt output, which stays high until the host reads the upper status byte. Two bits of the screen mode register are driven out as ROM and cartridge-RAM ownership signals.

Top module: `cpr_host_window`

## Requirements
- R1: General register Rn occupies offsets 2n (low byte) and 2n+1 (high byte) for n = 0..15. Each byte can be written and read back independently.
- R2: A write to offset 0x01F sets the running flag (status bit 5, read at offset 0x030) and raises `core_start` for exactly the one cycle after the write. A write to offset 0x01E alone does neither.
- R3: `core_stop` clears the running flag. If a write to 0x01F happens in the same cycle, the running flag ends up set.
- R4: While config bit 7 (offset 0x037) is 0, a pulse on `core_stop` or `core_irq_req` sets status bit 15 and `irq`. While config bit 7 is 1, neither pulse changes them.
- R5: A host read of offset 0x031 returns the status interrupt bit in data bit 7 and then clears that bit and `irq`. A set event in the same cycle as the read wins, so the bit stays set.
- R6: Host writes to the status word store only bits 1-4, 6 and 8-12. They never change bit 5 or bit 15, and bits 0, 7, 13 and 14 always read 0.
- R7: The cache base register (offsets 0x03E/0x03F) stores bits 15:4. Offset 0x03E always reads with bits 3:0 at 0.
- R8: Offset 0x03B reads the `VERSION` parameter (default 0x04), and host writes to it are ignored.
- R9: Offsets 0x100-0x2FF address cache RAM bytes that can be written and read back.
- R10: `rom_own` follows bit 4 and `ram_own` follows bit 3 of the screen mode register at offset 0x03A.
- R11: Unused offsets (0x020-0x02F, 0x032, 0x035, 0x03D, 0x040-0x0FF, 0x300-0x3FF) read 0x00 and ignore writes. After reset, every register reads 0 and both outputs `core_start` and `irq` are low.
- R12: `host_rdata` shows the addressed byte on the cycle after `host_rd` and holds it until the next read.
- R13: The backup-RAM enable register (0x033) and the clock select register (0x039) store only bit 0. The other 8-bit control registers (0x034, 0x036, 0x037, 0x038, 0x03A, 0x03C) store all 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 10 | Byte offset into the window |
| host_wr | input | 1 | Byte write strobe |
| host_rd | input | 1 | Byte read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after a read |
| core_stop | input | 1 | Core reports it has stopped |
| core_irq_req | input | 1 | Core requests an interrupt |
| core_start | output | 1 | One-cycle start pulse to the core |
| irq | output | 1 | Latched interrupt to the host |
| rom_own | output | 1 | Core owns the ROM |
| ram_own | output | 1 | Core owns the cartridge RAM |

## Verification
Register traffic is tried in several patterns, and each pattern tells a different fault apart:
- Distinct low and high byte values in several general registers expose swapped byte lanes and aliased register indexes.
- Cache bytes at the first, a middle and the last location, read back between register reads, separate the cache path from the register path in the read multiplexer.
- Start, stop, masked stop and interrupt-request pulses, each followed by status reads, show the running and interrupt flags moving independently.
- Two collisions are driven on purpose: a start written in the same cycle as a stop, and an interrupt request in the same cycle as the clearing status read. These show which event wins.
- Writes of all-ones to the status word, version, backup, clock and unused offsets show which bits are stored and which are ignored.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 8;
  localparam int REG_W    = 16;
  localparam int NUM_GPR  = 16;
  localparam int GPR_SEL_W = $clog2(NUM_GPR);

  // offsets inside the lower 256-byte page
  localparam logic [7:0] OFF_GPR_END = 8'h20;
  localparam logic [7:0] OFF_PC_HI   = 8'h1F;
  localparam logic [7:0] OFF_STAT_LO = 8'h30;
  localparam logic [7:0] OFF_STAT_HI = 8'h31;
  localparam logic [7:0] OFF_BKUP    = 8'h33;
  localparam logic [7:0] OFF_PBANK   = 8'h34;
  localparam logic [7:0] OFF_RBANK   = 8'h36;
  localparam logic [7:0] OFF_CFG     = 8'h37;
  localparam logic [7:0] OFF_SCRB    = 8'h38;
  localparam logic [7:0] OFF_CLK     = 8'h39;
  localparam logic [7:0] OFF_SMODE   = 8'h3A;
  localparam logic [7:0] OFF_VER     = 8'h3B;
  localparam logic [7:0] OFF_RAMBK   = 8'h3C;
  localparam logic [7:0] OFF_CBASE_LO = 8'h3E;
  localparam logic [7:0] OFF_CBASE_HI = 8'h3F;

  localparam logic [ADDR_W-1:0] CACHE_BASE = 10'h100;

  // status bit positions
  localparam int STAT_GO  = 5;
  localparam int STAT_IRQ = 15;
  localparam logic [15:0] STAT_WR_MASK = 16'h1F5E;

  // config / screen mode bit positions
  localparam int CFG_IRQ_MASK = 7;
  localparam int SMODE_ROM    = 4;
  localparam int SMODE_RAM    = 3;
endpackage

// File: rtl/cpr_gpr_file.sv
module cpr_gpr_file
  import cpr_pkg::*;
#(
  parameter int NREG = NUM_GPR
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NREG):0]   waddr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [$clog2(NREG):0]   raddr,
  output logic [DATA_W-1:0]       rdata
);
  localparam int SEL_W = $clog2(NREG);

  logic [REG_W-1:0] rd_vec [NREG];
  logic [SEL_W-1:0] wsel;
  logic [SEL_W-1:0] rsel;

  assign wsel = waddr[SEL_W:1];
  assign rsel = raddr[SEL_W:1];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [REG_W-1:0] q;
    logic [REG_W-1:0] d;
    logic             en;

    assign en = wr_en && (wsel == SEL_W'(g));

    always_comb begin
      d = q;
      if (waddr[0]) d[15:8] = wdata;
      else          d[7:0]  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign rd_vec[g] = q;
  end

  always_comb begin
    if (raddr[0]) rdata = rd_vec[rsel][15:8];
    else          rdata = rd_vec[rsel][7:0];
  end
endmodule

// File: rtl/cpr_ctrl_regs.sv
module cpr_ctrl_regs
  import cpr_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              start_i,
  input  logic              core_stop_i,
  input  logic              core_irq_req_i,
  output logic [DATA_W-1:0] rdata,
  output logic              go_o,
  output logic              irq_o,
  output logic              rom_own_o,
  output logic              ram_own_o
);
  logic [15:0] stat_q, stat_d;
  logic        bkup_q, bkup_d;
  logic [7:0]  pbank_q, pbank_d;
  logic [7:0]  rbank_q, rbank_d;
  logic [7:0]  cfg_q, cfg_d;
  logic [7:0]  scrb_q, scrb_d;
  logic        clk_q, clk_d;
  logic [7:0]  smode_q, smode_d;
  logic [7:0]  rambk_q, rambk_d;
  logic [11:0] cbase_q, cbase_d;

  logic set_evt;
  logic clr_evt;

  assign set_evt = (core_stop_i || core_irq_req_i) && !cfg_q[CFG_IRQ_MASK];
  assign clr_evt = rd_en && (addr == OFF_STAT_HI);

  // next-state
  always_comb begin
    stat_d  = stat_q;
    bkup_d  = bkup_q;
    pbank_d = pbank_q;
    rbank_d = rbank_q;
    cfg_d   = cfg_q;
    scrb_d  = scrb_q;
    clk_d   = clk_q;
    smode_d = smode_q;
    rambk_d = rambk_q;
    cbase_d = cbase_q;

    if (wr_en) begin
      case (addr)
        OFF_STAT_LO:  stat_d[7:0]  = (wdata & STAT_WR_MASK[7:0])  | (stat_q[7:0]  & ~STAT_WR_MASK[7:0]);
        OFF_STAT_HI:  stat_d[15:8] = (wdata & STAT_WR_MASK[15:8]) | (stat_q[15:8] & ~STAT_WR_MASK[15:8]);
        OFF_BKUP:     bkup_d  = wdata[0];
        OFF_PBANK:    pbank_d = wdata;
        OFF_RBANK:    rbank_d = wdata;
        OFF_CFG:      cfg_d   = wdata;
        OFF_SCRB:     scrb_d  = wdata;
        OFF_CLK:      clk_d   = wdata[0];
        OFF_SMODE:    smode_d = wdata;
        OFF_RAMBK:    rambk_d = wdata;
        OFF_CBASE_LO: cbase_d[3:0]  = wdata[7:4];
        OFF_CBASE_HI: cbase_d[11:4] = wdata;
        default: ;
      endcase
    end

    // interrupt: clear on read, set event wins
    if (clr_evt) stat_d[STAT_IRQ] = 1'b0;
    if (set_evt) stat_d[STAT_IRQ] = 1'b1;

    // running flag: start wins over stop
    if (core_stop_i) stat_d[STAT_GO] = 1'b0;
    if (start_i)     stat_d[STAT_GO] = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      bkup_q  <= 1'b0;
      pbank_q <= '0;
      rbank_q <= '0;
      cfg_q   <= '0;
      scrb_q  <= '0;
      clk_q   <= 1'b0;
      smode_q <= '0;
      rambk_q <= '0;
      cbase_q <= '0;
    end else begin
      stat_q  <= stat_d;
      bkup_q  <= bkup_d;
      pbank_q <= pbank_d;
      rbank_q <= rbank_d;
      cfg_q   <= cfg_d;
      scrb_q  <= scrb_d;
      clk_q   <= clk_d;
      smode_q <= smode_d;
      rambk_q <= rambk_d;
      cbase_q <= cbase_d;
    end
  end

  // read multiplexer
  always_comb begin
    case (addr)
      OFF_STAT_LO:  rdata = stat_q[7:0];
      OFF_STAT_HI:  rdata = stat_q[15:8];
      OFF_BKUP:     rdata = {7'd0, bkup_q};
      OFF_PBANK:    rdata = pbank_q;
      OFF_RBANK:    rdata = rbank_q;
      OFF_CFG:      rdata = cfg_q;
      OFF_SCRB:     rdata = scrb_q;
      OFF_CLK:      rdata = {7'd0, clk_q};
      OFF_SMODE:    rdata = smode_q;
      OFF_VER:      rdata = VERSION;
      OFF_RAMBK:    rdata = rambk_q;
      OFF_CBASE_LO: rdata = {cbase_q[3:0], 4'd0};
      OFF_CBASE_HI: rdata = cbase_q[11:4];
      default:      rdata = '0;
    endcase
  end

  assign go_o      = stat_q[STAT_GO];
  assign irq_o     = stat_q[STAT_IRQ];
  assign rom_own_o = smode_q[SMODE_ROM];
  assign ram_own_o = smode_q[SMODE_RAM];

  AST_IRQ_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !irq_o); // R5
  AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> irq_o); // R5
  AST_STOP_DROPS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stop_i && !start_i) |=> !go_o); // R3
  AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[CFG_IRQ_MASK] && !irq_o && !(wr_en && addr == OFF_CFG)) |=> !irq_o); // R4
endmodule

// File: rtl/cpr_cache_ram.sv
module cpr_cache_ram
  import cpr_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cpr_host_window.sv
module cpr_host_window
  import cpr_pkg::*;
#(
  parameter logic [7:0] VERSION     = 8'h04,
  parameter int         CACHE_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              core_stop,
  input  logic              core_irq_req,
  output logic              core_start,
  output logic              irq,
  output logic              rom_own,
  output logic              ram_own
);
  localparam int CIDX_W = $clog2(CACHE_BYTES);
  localparam logic [ADDR_W:0] CACHE_END = (ADDR_W+1)'(CACHE_BASE) + (ADDR_W+1)'(CACHE_BYTES);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // decode
  logic              low_page;
  logic              gpr_hit;
  logic              cache_hit;
  logic              pc_hi_wr;
  logic [CIDX_W-1:0] cache_idx;
  logic [ADDR_W-1:0] cache_off;

  assign low_page  = (host_addr[ADDR_W-1:8] == '0);
  assign gpr_hit   = low_page && (host_addr[7:0] < OFF_GPR_END);
  assign cache_hit = ({1'b0, host_addr} >= (ADDR_W+1)'(CACHE_BASE)) &&
                     ({1'b0, host_addr} <  CACHE_END);
  assign pc_hi_wr  = host_wr && low_page && (host_addr[7:0] == OFF_PC_HI);
  assign cache_off = host_addr - CACHE_BASE;
  assign cache_idx = cache_off[CIDX_W-1:0];

  // sub-blocks
  logic [DATA_W-1:0] gpr_rdata;
  logic [DATA_W-1:0] ctl_rdata;
  logic [DATA_W-1:0] cache_rdata;
  logic              go;

  cpr_gpr_file #(.NREG(NUM_GPR)) u_gpr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .wr_en (host_wr && gpr_hit),
    .waddr (host_addr[GPR_SEL_W:0]),
    .wdata (host_wdata),
    .raddr (host_addr[GPR_SEL_W:0]),
    .rdata (gpr_rdata)
  );

  cpr_ctrl_regs #(.VERSION(VERSION)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .wr_en          (host_wr && low_page),
    .rd_en          (host_rd && low_page),
    .addr           (host_addr[7:0]),
    .wdata          (host_wdata),
    .start_i        (pc_hi_wr),
    .core_stop_i    (core_stop),
    .core_irq_req_i (core_irq_req),
    .rdata          (ctl_rdata),
    .go_o           (go),
    .irq_o          (irq),
    .rom_own_o      (rom_own),
    .ram_own_o      (ram_own)
  );

  cpr_cache_ram #(.DEPTH(CACHE_BYTES)) u_cache (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (host_wr && cache_hit),
    .re    (host_rd && cache_hit),
    .addr  (cache_idx),
    .wdata (host_wdata),
    .rdata (cache_rdata)
  );

  // start pulse and read path: next-state
  logic              start_q, start_d;
  logic [DATA_W-1:0] regb_q, regb_d;
  logic              selc_q, selc_d;

  always_comb begin
    start_d = pc_hi_wr;
    regb_d  = regb_q;
    selc_d  = selc_q;
    if (host_rd) begin
      selc_d = cache_hit;
      if (!low_page)    regb_d = '0;
      else if (gpr_hit) regb_d = gpr_rdata;
      else              regb_d = ctl_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      start_q <= 1'b0;
      regb_q  <= '0;
      selc_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      regb_q  <= regb_d;
      selc_q  <= selc_d;
    end
  end

  assign core_start = start_q;
  assign host_rdata = selc_q ? cache_rdata : regb_q;

  AST_START_WITH_GO: assert property (@(posedge clk) disable iff (!rst_n_s)
    core_start |-> go); // R2
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (core_start && !$past(pc_hi_wr, 2)) |=> !core_start); // R2
  AST_CBASE_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_rd && low_page && host_addr[7:0] == OFF_CBASE_LO) |=> (host_rdata[3:0] == 4'd0)); // R7
  AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_rd && low_page && host_addr[7:0] >= 8'h20 && host_addr[7:0] < 8'h30) |=> (host_rdata == '0)); // R11
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq) |-> $past(core_stop || core_irq_req)); // R4
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!host_rd && !$past(host_rd)) |=> $stable(host_rdata)); // R12
endmodule

// File: tb/cpr_host_window_tb.sv
module cpr_host_window_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [9:0] host_addr;
  logic       host_wr;
  logic       host_rd;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       core_stop;
  logic       core_irq_req;
  logic       core_start;
  logic       irq;
  logic       rom_own;
  logic       ram_own;

  int checks;
  int errors;

  typedef struct {
    logic [9:0] addr;
    logic [7:0] exp;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  logic pend;

  cpr_host_window u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr    (host_addr),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .core_stop    (core_stop),
    .core_irq_req (core_irq_req),
    .core_start   (core_start),
    .irq          (irq),
    .rom_own      (rom_own),
    .ram_own      (ram_own)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: note which edges carried a read, compare on the following falling edge
  always @(posedge clk) pend <= rst_n && host_rd;

  always @(negedge clk) begin
    if (pend) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL %s: read result with empty scoreboard, actual %02h expected none", "R12", host_rdata);
      end else begin
        e = sb_q.pop_front();
        if (host_rdata !== e.exp) begin
          errors++;
          $display("FAIL %s: addr %03h actual %02h expected %02h", e.tag, e.addr, host_rdata, e.exp);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.addr = a; e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic pulse_stop();
    core_stop = 1'b1;
    @(negedge clk);
    core_stop = 1'b0;
  endtask

  task automatic pulse_irq();
    core_irq_req = 1'b1;
    @(negedge clk);
    core_irq_req = 1'b0;
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R12", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
    core_stop = 0; core_irq_req = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk(core_start == 0, "R11 start", core_start, 0);
    chk(irq == 0, "R11 irq", irq, 0);
    chk(rom_own == 0 && ram_own == 0, "R11 own", {rom_own, ram_own}, 0);
    rd(10'h030, 8'h00, "R11 stat lo");
    rd(10'h031, 8'h00, "R11 stat hi");
    rd(10'h000, 8'h00, "R11 r0");
    rd(10'h037, 8'h00, "R11 cfg");

    // R1 general registers, little-endian
    wr(10'h006, 8'hEF); wr(10'h007, 8'hBE);
    wr(10'h00A, 8'h34); wr(10'h00B, 8'h12);
    wr(10'h000, 8'h5A);
    rd(10'h006, 8'hEF, "R1 r3 lo");
    rd(10'h007, 8'hBE, "R1 r3 hi");
    rd(10'h00A, 8'h34, "R1 r5 lo");
    rd(10'h00B, 8'h12, "R1 r5 hi");
    rd(10'h001, 8'h00, "R1 r0 hi");
    rd(10'h000, 8'h5A, "R1 r0 lo");

    // R2 start on high byte of R15 only
    wr(10'h01E, 8'h80);
    chk(core_start == 0, "R2 low byte no start", core_start, 0);
    rd(10'h030, 8'h00, "R2 go clear");
    wr(10'h01F, 8'h01);
    chk(core_start == 1, "R2 start pulse", core_start, 1);
    @(negedge clk);
    chk(core_start == 0, "R2 start one cycle", core_start, 0);
    rd(10'h030, 8'h20, "R2 go set");
    rd(10'h01E, 8'h80, "R1 pc lo");
    rd(10'h01F, 8'h01, "R1 pc hi");

    // R3/R4/R5 stop with unmasked interrupt
    pulse_stop();
    chk(irq == 1, "R4 stop irq", irq, 1);
    rd(10'h030, 8'h00, "R3 go cleared");
    rd(10'h031, 8'h80, "R5 irq bit read");
    chk(irq == 0, "R5 irq cleared", irq, 0);
    rd(10'h031, 8'h00, "R5 irq bit gone");

    // R4 masked
    wr(10'h037, 8'h80);
    rd(10'h037, 8'h80, "R13 cfg");
    wr(10'h01F, 8'h02);
    pulse_stop();
    chk(irq == 0, "R4 masked stop", irq, 0);
    pulse_irq();
    chk(irq == 0, "R4 masked irq req", irq, 0);
    rd(10'h030, 8'h00, "R3 go cleared masked");
    rd(10'h031, 8'h00, "R4 masked stat hi");

    // R4/R5 interrupt request and collision with the clearing read
    wr(10'h037, 8'h00);
    pulse_irq();
    chk(irq == 1, "R4 irq req", irq, 1);
    core_irq_req = 1'b1;
    rd(10'h031, 8'h80, "R5 collide read");
    core_irq_req = 1'b0;
    chk(irq == 1, "R5 set wins", irq, 1);
    rd(10'h031, 8'h80, "R5 still set");
    chk(irq == 0, "R5 cleared after", irq, 0);

    // R3 start and stop in the same cycle
    core_stop = 1'b1;
    wr(10'h01F, 8'h03);
    core_stop = 1'b0;
    rd(10'h030, 8'h20, "R3 start wins");
    pulse_stop();
    rd(10'h030, 8'h00, "R3 stop after");
    rd(10'h031, 8'h80, "R5 clear after stop");

    // R6 status writes
    wr(10'h030, 8'hFF);
    rd(10'h030, 8'h5E, "R6 stat lo mask");
    wr(10'h031, 8'hFF);
    rd(10'h031, 8'h1F, "R6 stat hi mask");
    chk(irq == 0, "R6 irq not writable", irq, 0);
    wr(10'h030, 8'h00); wr(10'h031, 8'h00);
    rd(10'h030, 8'h00, "R6 stat lo clear");

    // R7 cache base
    wr(10'h03E, 8'hAB); wr(10'h03F, 8'hCD);
    rd(10'h03E, 8'hA0, "R7 cbase lo");
    rd(10'h03F, 8'hCD, "R7 cbase hi");

    // R8 version
    rd(10'h03B, 8'h04, "R8 version");
    wr(10'h03B, 8'hFF);
    rd(10'h03B, 8'h04, "R8 version write ignored");

    // R9 cache RAM interleaved with register reads
    wr(10'h100, 8'h11); wr(10'h1FF, 8'h22); wr(10'h2FF, 8'h33);
    rd(10'h100, 8'h11, "R9 cache first");
    rd(10'h006, 8'hEF, "R12 reg after cache");
    rd(10'h1FF, 8'h22, "R9 cache mid");
    rd(10'h2FF, 8'h33, "R9 cache last");
    rd(10'h00B, 8'h12, "R12 reg after cache 2");

    // R12 hold
    repeat (2) @(negedge clk);
    chk(host_rdata == 8'h12, "R12 hold", host_rdata, 8'h12);

    // R10 ownership
    wr(10'h03A, 8'h10);
    chk(rom_own == 1 && ram_own == 0, "R10 rom own", {rom_own, ram_own}, 2);
    wr(10'h03A, 8'h08);
    chk(rom_own == 0 && ram_own == 1, "R10 ram own", {rom_own, ram_own}, 1);
    rd(10'h03A, 8'h08, "R10 smode readback");

    // R11 unused offsets
    wr(10'h020, 8'h55); wr(10'h032, 8'h55); wr(10'h040, 8'h55); wr(10'h300, 8'h55);
    rd(10'h020, 8'h00, "R11 unused 020");
    rd(10'h032, 8'h00, "R11 unused 032");
    rd(10'h040, 8'h00, "R11 unused 040");
    rd(10'h300, 8'h00, "R11 unused 300");
    rd(10'h100, 8'h11, "R11 cache untouched");

    // R13 bit-0-only registers and full bytes
    wr(10'h033, 8'hFF); wr(10'h039, 8'hFE); wr(10'h034, 8'hA5); wr(10'h03C, 8'h3C);
    rd(10'h033, 8'h01, "R13 backup");
    rd(10'h039, 8'h00, "R13 clock");
    rd(10'h034, 8'hA5, "R13 prog bank");
    rd(10'h03C, 8'h3C, "R13 ram bank");

    finish_run();
  end
endmodule